// File: doc/BRIEF.md
# SD Command Line Engine

This block owns the single-bit command wire of an SD card interface. Host logic first loads a 32-bit argument and then writes a command word. That word holds a 6-bit index, flags for "response expected", "long response" and "application command", a start (enable) bit and a soft-reset bit. The engine serializes a 48-bit frame protected by CRC7. It then either finishes at once or releases the wire and listens for a 48-bit or 136-bit reply from the card.

Captured replies land in four 32-bit response words and a small echo register. The echo register holds the returned index together with the application flag of the command that was issued. Every transaction ends with exactly one one-cycle status pulse. All bit timing advances on a clock-enable strobe derived from the SD clock, so the engine runs in the system clock domain. A self-clearing soft reset aborts any transaction and returns the engine to its idle state.

Top module: `sd_cmd_unit`

## Requirements
- R1: After the synchronous reset, the command readback, all four response words and the echo register read 0, `cmd_oe` is 0 and `cmd_out` is 1.
- R2: The command word fields are: index in bits 5:0, response expected in bit 6, long response in bit 7, application flag in bit 8, start in bit 9 and soft reset in bit 10. A write with bit 9 set while bit 9 reads 0 starts one transaction. Bit 9 reads 1 until the transaction's status pulse and 0 afterwards. Any write without bit 10 made while bit 9 reads 1 is ignored.
- R3: A transaction without response ends with exactly one `st_sent` pulse. A transaction with response ends with exactly one of `st_rsp_ok`, `st_rsp_bad` or `st_rsp_timeout`, and no `st_sent`.
- R4: The frame is 48 bits, sent MSB first with one bit per strobe. It consists of a 0 bit, a 1 bit, the 6-bit index, the 32-bit argument, the CRC7 (x^7+x^3+1, zero seed) of those first 40 bits, and a final 1 bit. For index 0 with argument 0, the CRC is 7'h4A.
- R5: A short reply has 48 bits: start 0, transmission bit 0, index, 32-bit field, CRC7, end 1. Its 32-bit field is stored in `resp0`, and `resp1`..`resp3` keep their values. The outcome is ok only when the CRC7 over the first 40 reply bits matches, the transmission bit is 0 and the end bit is 1; otherwise it is bad.
- R6: A long reply has 136 bits. V is formed from the 127 bits that follow the 8 header bits, in arrival order, with a 0 appended. `resp0` receives V[31:0], `resp1` V[63:32], `resp2` V[95:64] and `resp3` V[127:96]. The reply CRC is not recomputed. The outcome is ok when the transmission bit is 0 and the end bit is 1; otherwise it is bad.
- R7: After any received reply, `resp_cmd[5:0]` holds the reply's index field and `resp_cmd[6]` holds the application flag of the issued command.
- R8: If the line stays high on all 64 strobes after the frame's end bit, the transaction ends in a timeout. A start bit seen on the 64th strobe is accepted.
- R9: `cmd_oe` is 1 only while a frame is being sent. It stays 0 while the engine waits for or receives a reply. Whenever `cmd_oe` is 0, `cmd_out` is 1.
- R10: Writing bit 10 makes bit 10 read 1 on the next cycle. It aborts any transaction without a status pulse and clears the command fields, the argument, the response words and the echo register. Bit 10 reads 0 again after RST_CYCLES clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_clk_en | input | 1 | One-cycle strobe per SD clock period |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 11 | Command word to write |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument to write |
| cmd_rdata | output | 11 | Command word readback (start and reset bits live) |
| resp0 | output | 32 | Response word 0 (least significant) |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 (most significant) |
| resp_cmd | output | 7 | Reply index and application flag |
| st_sent | output | 1 | Pulse: command without response completed |
| st_rsp_ok | output | 1 | Pulse: reply accepted |
| st_rsp_bad | output | 1 | Pulse: reply failed CRC or framing check |
| st_rsp_timeout | output | 1 | Pulse: no reply start bit in time |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line input value |

## Verification
The hardest situations to reach are the edges of the reply window: a start bit arriving on exactly the 64th strobe versus none at all. The other is a soft reset landing in the middle of a frame. The bench acts as the card, sampling the line on the negative edge after each strobe. It counts strobes from the moment it sees the output enable drop, so it can place the first reply bit on strobe 64, or never, with no reference to internal counters. For the abort case, a reset word is written forty cycles into a frame that expects a response. The bench then watches for the line to be released and for no status pulse during a long quiet window.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int IDX_W      = 6;
  localparam int ARG_W      = 32;
  localparam int CRC_W      = 7;
  localparam int CMD_W      = 11;
  localparam int HDR_BITS   = 40;   // bits covered by the frame CRC
  localparam int FRAME_BITS = 48;
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int WORD_W     = 128;

  // command word bit positions (decoded by host software)
  localparam int B_NEED = 6;
  localparam int B_LONG = 7;
  localparam int B_APP  = 8;
  localparam int B_EN   = 9;
  localparam int B_RST  = 10;

  typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_RECV} rx_state_t;

  // one serial step of CRC7, generator x^7 + x^3 + 1
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c,
                                                 input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction
endpackage

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             stb,
  input  logic             start,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             line_out,
  output logic             line_oe,
  output logic             done
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [HDR_BITS-1:0] shreg;
  logic [CRC_W-1:0]    crc;
  logic [CNT_W-1:0]    cnt;
  logic                active;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active   <= 1'b0;
      line_oe  <= 1'b0;
      line_out <= 1'b1;
      done     <= 1'b0;
      cnt      <= '0;
      crc      <= '0;
      shreg    <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        shreg  <= {2'b01, idx, arg};
        cnt    <= '0;
        crc    <= '0;
      end else if (active && stb) begin
        cnt <= cnt + 1'b1;
        if (cnt < CNT_W'(HDR_BITS)) begin
          line_oe  <= 1'b1;
          line_out <= shreg[HDR_BITS-1];
          shreg    <= {shreg[HDR_BITS-2:0], 1'b0};
          crc      <= crc7_step(crc, shreg[HDR_BITS-1]);
        end else if (cnt < CNT_W'(FRAME_BITS - 1)) begin
          line_out <= crc[CRC_W-1];
          crc      <= {crc[CRC_W-2:0], 1'b0};
        end else if (cnt == CNT_W'(FRAME_BITS - 1)) begin
          line_out <= 1'b1;
        end else begin
          line_oe  <= 1'b0;
          line_out <= 1'b1;
          active   <= 1'b0;
          done     <= 1'b1;
        end
      end
    end
  end

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !line_oe |-> line_out);

  // R4
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(line_oe) |-> !line_out);
endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
  import sd_cmd_pkg::*;
#(
  parameter int TO_CLKS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              stb,
  input  logic              start,
  input  logic              long_rsp,
  input  logic              line_in,
  output logic              busy,
  output logic              rsp_ok,
  output logic              rsp_bad,
  output logic              rsp_to,
  output logic [WORD_W-1:0] rsp_word,
  output logic [IDX_W-1:0]  rsp_idx
);
  localparam int TO_W  = $clog2(TO_CLKS + 1);
  localparam int BC_W  = $clog2(LONG_BITS);
  localparam int SH_W  = LONG_BITS - 2;   // bits kept behind the incoming one

  rx_state_t         state;
  logic [TO_W-1:0]   to_cnt;
  logic [BC_W-1:0]   bcnt;
  logic [SH_W-1:0]   shreg;
  logic [CRC_W-1:0]  crc;
  logic              long_q;
  logic [SH_W:0]     nxt;
  logic              last_bit;
  logic              short_good;
  logic              long_good;

  assign nxt      = {shreg, line_in};
  assign last_bit = (bcnt == (long_q ? BC_W'(LONG_BITS - 2) : BC_W'(SHORT_BITS - 2)));
  assign short_good = (crc == nxt[CRC_W:1]) && nxt[0] && !nxt[SHORT_BITS-2];
  assign long_good  = nxt[0] && !nxt[LONG_BITS-2];
  assign busy     = (state != RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state    <= RX_IDLE;
      to_cnt   <= '0;
      bcnt     <= '0;
      shreg    <= '0;
      crc      <= '0;
      long_q   <= 1'b0;
      rsp_ok   <= 1'b0;
      rsp_bad  <= 1'b0;
      rsp_to   <= 1'b0;
      rsp_word <= '0;
      rsp_idx  <= '0;
    end else begin
      rsp_ok  <= 1'b0;
      rsp_bad <= 1'b0;
      rsp_to  <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (start) begin
            state  <= RX_WAIT;
            to_cnt <= '0;
            long_q <= long_rsp;
          end
        end
        RX_WAIT: begin
          if (stb) begin
            if (!line_in) begin
              state <= RX_RECV;
              bcnt  <= '0;
              crc   <= '0;
            end else if (to_cnt == TO_W'(TO_CLKS - 1)) begin
              state  <= RX_IDLE;
              rsp_to <= 1'b1;
            end else begin
              to_cnt <= to_cnt + 1'b1;
            end
          end
        end
        RX_RECV: begin
          if (stb) begin
            shreg <= nxt[SH_W-1:0];
            bcnt  <= bcnt + 1'b1;
            if (bcnt < BC_W'(HDR_BITS - 1))
              crc <= crc7_step(crc, line_in);
            if (last_bit) begin
              state <= RX_IDLE;
              if (long_q) begin
                rsp_word <= {nxt[WORD_W-1:1], 1'b0};
                rsp_idx  <= nxt[WORD_W+IDX_W-1:WORD_W];
                rsp_ok   <= long_good;
                rsp_bad  <= !long_good;
              end else begin
                rsp_word <= {{(WORD_W-ARG_W){1'b0}}, nxt[ARG_W+CRC_W:CRC_W+1]};
                rsp_idx  <= nxt[ARG_W+CRC_W+IDX_W:ARG_W+CRC_W+1];
                rsp_ok   <= short_good;
                rsp_bad  <= !short_good;
              end
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_ok, rsp_bad, rsp_to}));

  // R8
  timeout_line_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_to |-> ($past(line_in) && $past(stb)));
endmodule

// File: rtl/sd_cmd_unit.sv
module sd_cmd_unit
  import sd_cmd_pkg::*;
#(
  parameter int TO_CLKS    = 64,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sd_clk_en,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              arg_wr,
  input  logic [ARG_W-1:0]  arg_wdata,
  output logic [CMD_W-1:0]  cmd_rdata,
  output logic [ARG_W-1:0]  resp0,
  output logic [ARG_W-1:0]  resp1,
  output logic [ARG_W-1:0]  resp2,
  output logic [ARG_W-1:0]  resp3,
  output logic [IDX_W:0]    resp_cmd,
  output logic              st_sent,
  output logic              st_rsp_ok,
  output logic              st_rsp_bad,
  output logic              st_rsp_timeout,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              cmd_in
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [IDX_W-1:0] idx_q;
  logic             need_q, long_q, app_q, en_q, rst_q;
  logic [RC_W-1:0]  rst_cnt;
  logic [ARG_W-1:0] arg_q;

  logic              tx_start, tx_done;
  logic              rx_start, rx_busy, rx_ok, rx_bad, rx_to;
  logic [WORD_W-1:0] rx_word;
  logic [IDX_W-1:0]  rx_idx;

  assign tx_start = cmd_wr && !cmd_wdata[B_RST] && cmd_wdata[B_EN] && !en_q && !rst_q;
  assign rx_start = tx_done && need_q && !rst_q;
  assign cmd_rdata = {rst_q, en_q, app_q, long_q, need_q, idx_q};

  sd_cmd_tx u_tx (
    .clk      (clk),
    .rst      (rst),
    .clr      (rst_q),
    .stb      (sd_clk_en),
    .start    (tx_start),
    .idx      (cmd_wdata[IDX_W-1:0]),
    .arg      (arg_q),
    .line_out (cmd_out),
    .line_oe  (cmd_oe),
    .done     (tx_done)
  );

  sd_cmd_rx #(.TO_CLKS(TO_CLKS)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .clr      (rst_q),
    .stb      (sd_clk_en),
    .start    (rx_start),
    .long_rsp (long_q),
    .line_in  (cmd_in),
    .busy     (rx_busy),
    .rsp_ok   (rx_ok),
    .rsp_bad  (rx_bad),
    .rsp_to   (rx_to),
    .rsp_word (rx_word),
    .rsp_idx  (rx_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0; need_q <= 1'b0; long_q <= 1'b0; app_q <= 1'b0;
      en_q  <= 1'b0; rst_q <= 1'b0; rst_cnt <= '0; arg_q <= '0;
      resp0 <= '0; resp1 <= '0; resp2 <= '0; resp3 <= '0; resp_cmd <= '0;
      st_sent <= 1'b0; st_rsp_ok <= 1'b0; st_rsp_bad <= 1'b0; st_rsp_timeout <= 1'b0;
    end else begin
      st_sent        <= 1'b0;
      st_rsp_ok      <= 1'b0;
      st_rsp_bad     <= 1'b0;
      st_rsp_timeout <= 1'b0;
      if (rst_q) begin
        rst_cnt <= rst_cnt + 1'b1;
        if (rst_cnt == RC_W'(RST_CYCLES - 1)) rst_q <= 1'b0;
      end else if (cmd_wr && cmd_wdata[B_RST]) begin
        rst_q <= 1'b1; rst_cnt <= '0;
        idx_q <= '0; need_q <= 1'b0; long_q <= 1'b0; app_q <= 1'b0;
        en_q  <= 1'b0; arg_q <= '0;
        resp0 <= '0; resp1 <= '0; resp2 <= '0; resp3 <= '0; resp_cmd <= '0;
      end else begin
        if (cmd_wr && !en_q) begin
          idx_q  <= cmd_wdata[IDX_W-1:0];
          need_q <= cmd_wdata[B_NEED];
          long_q <= cmd_wdata[B_LONG];
          app_q  <= cmd_wdata[B_APP];
          en_q   <= cmd_wdata[B_EN];
        end
        if (arg_wr) arg_q <= arg_wdata;
        if (tx_done && !need_q) begin
          st_sent <= 1'b1;
          en_q    <= 1'b0;
        end
        if (rx_ok || rx_bad || rx_to) begin
          st_rsp_ok      <= rx_ok;
          st_rsp_bad     <= rx_bad;
          st_rsp_timeout <= rx_to;
          en_q           <= 1'b0;
        end
        if (rx_ok || rx_bad) begin
          resp0    <= rx_word[ARG_W-1:0];
          resp_cmd <= {app_q, rx_idx};
          if (long_q) begin
            resp1 <= rx_word[2*ARG_W-1:ARG_W];
            resp2 <= rx_word[3*ARG_W-1:2*ARG_W];
            resp3 <= rx_word[4*ARG_W-1:3*ARG_W];
          end
        end
      end
    end
  end

  // R3
  one_status_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_sent, st_rsp_ok, st_rsp_bad, st_rsp_timeout}));

  // R9
  released_chk: assert property (@(posedge clk) disable iff (rst)
    rx_busy |-> !cmd_oe);

  // R10
  rst_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_wdata[B_RST]) |=> cmd_rdata[B_RST]);

  // R2
  en_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_rdata[B_EN]) |->
      (st_sent || st_rsp_ok || st_rsp_bad || st_rsp_timeout || cmd_rdata[B_RST]));

  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_rdata[B_EN] && !cmd_wdata[B_RST]) |=> $stable(cmd_rdata[IDX_W-1:0]));
endmodule

// File: tb/sd_cmd_unit_test.sv
module sd_cmd_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYCLES = 8;
  localparam int TO_CLKS    = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sd_clk_en = 1'b0;
  logic        stb_d = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [10:0] cmd_wdata = '0;
  logic        arg_wr = 1'b0;
  logic [31:0] arg_wdata = '0;
  logic        cmd_in = 1'b1;
  logic [10:0] cmd_rdata;
  logic [31:0] resp0, resp1, resp2, resp3;
  logic [6:0]  resp_cmd;
  logic        st_sent, st_rsp_ok, st_rsp_bad, st_rsp_timeout;
  logic        cmd_out, cmd_oe;

  int div = 0;
  int n_sent = 0, n_ok = 0, n_bad = 0, n_to = 0;
  int checks = 0, fails = 0;

  sd_cmd_unit #(.TO_CLKS(TO_CLKS), .RST_CYCLES(RST_CYCLES)) uut (
    .clk(clk), .rst(rst), .sd_clk_en(sd_clk_en),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .arg_wr(arg_wr), .arg_wdata(arg_wdata),
    .cmd_rdata(cmd_rdata), .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3),
    .resp_cmd(resp_cmd), .st_sent(st_sent), .st_rsp_ok(st_rsp_ok),
    .st_rsp_bad(st_rsp_bad), .st_rsp_timeout(st_rsp_timeout),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    div       <= (div == 3) ? 0 : div + 1;
    sd_clk_en <= (div == 3);
    stb_d     <= sd_clk_en;
    if (!rst) begin
      if (st_sent)        n_sent <= n_sent + 1;
      if (st_rsp_ok)      n_ok   <= n_ok + 1;
      if (st_rsp_bad)     n_bad  <= n_bad + 1;
      if (st_rsp_timeout) n_to   <= n_to + 1;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] v);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb;
      fb = v[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    h = {2'b01, idx, arg};
    return {h, ref_crc(h), 1'b1};
  endfunction

  function automatic logic [10:0] cw(input bit need, input bit lng, input bit app,
                                     input logic [5:0] idx);
    return {1'b0, 1'b1, app, lng, need, idx};
  endfunction

  task automatic wr_cmd(input logic [10:0] v);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = v;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wr_arg(input logic [31:0] v);
    @(negedge clk); arg_wr = 1'b1; arg_wdata = v;
    @(negedge clk); arg_wr = 1'b0;
  endtask

  // Card-side sampling: one bit per strobe while the engine drives the line.
  task automatic capture(output logic [47:0] f, output int n);
    bit started = 0;
    f = '0; n = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (stb_d) begin
        if (cmd_oe) begin
          f = {f[46:0], cmd_out}; n++; started = 1;
        end else if (started) break;
      end
    end
  endtask

  // Hold line high for d strobes, then send n bits MSB first; checks release.
  task automatic respond(input int d, input logic [135:0] v, input int n,
                         output bit released);
    released = 1;
    cmd_in = 1'b1;
    for (int i = 0; i < d; i++) begin
      @(negedge clk iff stb_d);
      if (cmd_oe || !cmd_out) released = 0;
    end
    for (int i = n - 1; i >= 0; i--) begin
      cmd_in = v[i];
      @(negedge clk iff stb_d);
      if (cmd_oe || !cmd_out) released = 0;
    end
    cmd_in = 1'b1;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (!cmd_rdata[9]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_status(input string req, input int s0, input int o0,
                               input int b0, input int t0, input logic [3:0] exp);
    logic [3:0] act;
    act = {4'(n_sent - s0), 4'(n_ok - o0), 4'(n_bad - b0), 4'(n_to - t0)} == 16'h0 ? 4'h0 :
          {(n_sent - s0) == 1, (n_ok - o0) == 1, (n_bad - b0) == 1, (n_to - t0) == 1};
    if ((n_sent - s0) + (n_ok - o0) + (n_bad - b0) + (n_to - t0) > 1) act = 4'hF;
    check(act == exp, req, 128'(act), 128'(exp));
  endtask

  function automatic logic [47:0] short_rsp(input logic [5:0] idx, input logic [31:0] f,
                                            input bit bad_crc, input bit bad_end);
    logic [39:0] h;
    h = {2'b00, idx, f};
    return {h, ref_crc(h) ^ {6'b0, bad_crc}, !bad_end};
  endfunction

  localparam logic [126:0] LONG_BODY =
    {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 31'h5A5A5A5A};

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(cmd_rdata == 11'h0, "R1 cmd readback", 128'(cmd_rdata), 128'h0);
    check({resp0, resp1, resp2, resp3} == '0, "R1 response words",
          {resp0, resp1, resp2, resp3}, 128'h0);
    check(resp_cmd == 7'h0, "R1 echo", 128'(resp_cmd), 128'h0);
    check({cmd_oe, cmd_out} == 2'b01, "R1 line idle", 128'({cmd_oe, cmd_out}), 128'h1);
  endtask

  task automatic t_no_rsp(input logic [5:0] idx, input logic [31:0] arg);
    logic [47:0] f; int n; int s, o, b, t;
    s = n_sent; o = n_ok; b = n_bad; t = n_to;
    wr_arg(arg);
    wr_cmd(cw(0, 0, 0, idx));
    check(cmd_rdata[9], "R2 start bit reads 1 while busy", 128'(cmd_rdata), 128'h200);
    capture(f, n);
    check(n == 48 && f == ref_frame(idx, arg), "R4 frame", 128'(f), 128'(ref_frame(idx, arg)));
    wait_idle();
    check(!cmd_rdata[9] && cmd_rdata[5:0] == idx, "R2 start bit cleared",
          128'(cmd_rdata), 128'(idx));
    expect_status("R3 sent only", s, o, b, t, 4'b1000);
  endtask

  task automatic t_crc_const();
    check(ref_frame(6'd0, 32'd0) == 48'h40_0000_0000_95, "R4 CMD0 CRC 4A",
          128'(ref_frame(6'd0, 32'd0)), 128'h4000000000_95);
  endtask

  task automatic t_long(input bit end_ok);
    logic [47:0] f; int n; bit rel; int s, o, b, t; logic [127:0] v;
    s = n_sent; o = n_ok; b = n_bad; t = n_to;
    wr_arg(32'h0000_0000);
    wr_cmd(cw(1, 1, 0, 6'd2));
    capture(f, n);
    respond(3, {2'b00, 6'h3F, LONG_BODY, end_ok}, 136, rel);
    wait_idle();
    v = {LONG_BODY, 1'b0};
    check(rel, "R9 released during long reply", 128'(rel), 128'h1);
    if (end_ok) begin
      check(resp0 == v[31:0] && resp1 == v[63:32], "R6 low words",
            {64'h0, resp1, resp0}, {64'h0, v[63:0]});
      check(resp2 == v[95:64] && resp3 == v[127:96], "R6 high words",
            {64'h0, resp3, resp2}, {64'h0, v[127:64]});
      check(resp_cmd == 7'h3F, "R7 long echo", 128'(resp_cmd), 128'h3F);
      expect_status("R6 long ok", s, o, b, t, 4'b0100);
    end else begin
      expect_status("R6 long end bit bad", s, o, b, t, 4'b0010);
    end
  endtask

  task automatic t_short(input string req, input int d, input bit bad_crc,
                         input bit bad_end, input logic [3:0] exp);
    logic [47:0] f; int n; bit rel; int s, o, b, t;
    logic [31:0] r1, r2, r3;
    s = n_sent; o = n_ok; b = n_bad; t = n_to;
    r1 = resp1; r2 = resp2; r3 = resp3;
    wr_arg(32'hA5A5_0001);
    wr_cmd(cw(1, 0, 1, 6'd41));
    capture(f, n);
    check(f == ref_frame(6'd41, 32'hA5A5_0001), "R4 frame with response",
          128'(f), 128'(ref_frame(6'd41, 32'hA5A5_0001)));
    respond(d, 136'(short_rsp(6'd41, 32'hC0FF_EE12, bad_crc, bad_end)), 48, rel);
    wait_idle();
    check(rel, "R9 released during short reply", 128'(rel), 128'h1);
    expect_status(req, s, o, b, t, exp);
    if (exp == 4'b0100) begin
      check(resp0 == 32'hC0FF_EE12, "R5 resp0 field", 128'(resp0), 128'hC0FFEE12);
      check({resp1, resp2, resp3} == {r1, r2, r3}, "R5 upper words kept",
            128'({resp1, resp2, resp3}), 128'({r1, r2, r3}));
      check(resp_cmd == {1'b1, 6'd41}, "R7 echo with app flag",
            128'(resp_cmd), 128'({1'b1, 6'd41}));
    end
  endtask

  task automatic t_timeout();
    logic [47:0] f; int n; bit rel; int s, o, b, t; logic [31:0] r0;
    s = n_sent; o = n_ok; b = n_bad; t = n_to; r0 = resp0;
    wr_cmd(cw(1, 0, 0, 6'd13));
    capture(f, n);
    respond(TO_CLKS, '0, 0, rel);
    wait_idle();
    expect_status("R8 timeout after 64 high strobes", s, o, b, t, 4'b0001);
    check(resp0 == r0, "R8 resp0 untouched on timeout", 128'(resp0), 128'(r0));
  endtask

  task automatic t_busy_ignore();
    logic [47:0] f; int n; int s, o, b, t;
    s = n_sent; o = n_ok; b = n_bad; t = n_to;
    wr_arg(32'h1357_9BDF);
    wr_cmd(cw(0, 0, 0, 6'd5));
    fork
      capture(f, n);
      begin
        repeat (40) @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = cw(1, 1, 1, 6'd9);
        @(negedge clk); cmd_wr = 1'b0;
      end
    join
    wait_idle();
    check(f == ref_frame(6'd5, 32'h1357_9BDF), "R2 write while busy ignored (frame)",
          128'(f), 128'(ref_frame(6'd5, 32'h1357_9BDF)));
    check(cmd_rdata == {5'b00000, 6'd5}, "R2 write while busy ignored (fields)",
          128'(cmd_rdata), 128'(6'd5));
    expect_status("R3 busy case single sent", s, o, b, t, 4'b1000);
  endtask

  task automatic t_soft_reset();
    int s, o, b, t; bit quiet = 1;
    wr_arg(32'hFFFF_0000);
    wr_cmd(cw(1, 0, 0, 6'd8));
    repeat (40) @(negedge clk);
    s = n_sent; o = n_ok; b = n_bad; t = n_to;
    wr_cmd(11'h400);
    check(cmd_rdata[10], "R10 reset bit reads 1", 128'(cmd_rdata), 128'h400);
    repeat (2) @(negedge clk);
    check(!cmd_oe && cmd_out, "R10 frame aborted, line released",
          128'({cmd_oe, cmd_out}), 128'h1);
    repeat (RST_CYCLES + 2) @(negedge clk);
    check(cmd_rdata == 11'h0, "R10 reset bit self-clears", 128'(cmd_rdata), 128'h0);
    check({resp0, resp1, resp2, resp3} == '0 && resp_cmd == '0, "R10 responses cleared",
          {resp0, resp1, resp2, resp3}, 128'h0);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (cmd_oe) quiet = 0;
    end
    check(quiet, "R10 line stays released", 128'(quiet), 128'h1);
    expect_status("R10 no status after abort", s, o, b, t, 4'b0000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_crc_const();
    t_no_rsp(6'd0, 32'h0000_0000);
    t_no_rsp(6'd17, 32'h1234_5678);
    t_long(1'b1);
    t_short("R5 short ok", 2, 0, 0, 4'b0100);
    t_short("R5 short CRC bad", 0, 1, 0, 4'b0010);
    t_short("R5 short end bit bad", 5, 0, 1, 4'b0010);
    t_timeout();
    t_short("R8 start on strobe 64 accepted", TO_CLKS - 1, 0, 0, 4'b0100);
    t_long(1'b0);
    t_busy_ignore();
    t_soft_reset();
    t_no_rsp(6'd55, 32'h0F0F_F0F0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule